// File: doc/BRIEF.md
# Selectable Polyhedral Dice Roller

This block rolls one die and shows the result. A 2-bit selector sets the die at run time: it can have 4, 6, 8 or 20 sides. A 16-bit linear feedback shift register runs all the time, one step per clock, whether or not a roll is requested. When the roll request input goes from low to high, the block samples the current random word. It reduces that word to a face value between 1 and N, where N is the number of sides of the selected die, and places the value in an 8-bit output register.

The face value stays in the output register until the next rising edge of the roll request. Holding the request high produces no further values. Changing the selector between rolls does not change the value shown. The random word is wide compared with every die size, so the modulo step gives an almost even spread of faces, even for 6 and 20 sides. Because the source keeps running between presses, the results depend on when each press arrives.

Top module: `poly_die_roller`

## Requirements
- R1: Driving `rst_n` low clears `face` to 0 at once, without waiting for a clock edge, and `face` stays 0 until the first roll.
- R2: The selector `die_sel` encodes the number of sides N as follows: 2'b00 means 4, 2'b01 means 6, 2'b10 means 8 and 2'b11 means 20.
- R3: A roll is taken on the first clock edge at which `roll_req` is high after being low. `face` takes its new value at that same edge.
- R4: Between two rising edges of `roll_req`, `face` holds its value. This is true while `roll_req` stays high and while `die_sel` changes.
- R5: Every rolled value lies in the range 1 to N for the `die_sel` value present at the roll edge. The value is the 16-bit random word modulo N, plus 1.
- R6: For every die, each face from 1 to N appears within 300 rolls.
- R7: The random source is never zero and moves to a new state on every clock cycle after reset, whatever `roll_req` does. As a result, successive rolls vary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| die_sel | input | 2 | Die size selector (4/6/8/20 sides) |
| roll_req | input | 1 | Roll request; its rising edge triggers a roll |
| face | output | 8 | Last rolled value, 0 after reset |

## Verification
The bench runs 300 rolls on each of the four dice. The gap between presses changes from roll to roll, so the sampled words come from different positions of the source. Every result is checked against the bounds 1 to N, which shows whether the selector decodes to the right size. A tally of faces must then reach every value from 1 to N and never exceed N. Separate patterns test what must not cause a roll: a request held high for several cycles, and a selector change while idle. A reset in the middle of a run shows that clearing does not wait for a clock edge. The first roll after reset shows that the result appears at the edge where the request is first seen high.

// File: rtl/die_pkg.sv
package die_pkg;
    localparam int RND_W  = 16;
    localparam int FACE_W = 8;

    typedef enum logic [1:0] {
        DIE_D4  = 2'b00,
        DIE_D6  = 2'b01,
        DIE_D8  = 2'b10,
        DIE_D20 = 2'b11
    } die_kind_e;

    typedef struct packed {
        logic              roll_prev;
        logic [FACE_W-1:0] face;
    } roller_state_t;

    function automatic logic [FACE_W-1:0] sides_of(input die_kind_e kind);
        case (kind)
            DIE_D4:  sides_of = FACE_W'(4);
            DIE_D6:  sides_of = FACE_W'(6);
            DIE_D8:  sides_of = FACE_W'(8);
            default: sides_of = FACE_W'(20);
        endcase
    endfunction
endpackage

// File: rtl/die_lfsr.sv
module die_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   SEED = 16'hACE1,
    parameter logic [W-1:0]   TAPS = 16'hD008
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);
    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = {state_q[W-2:0], ^(state_q & TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign rnd = state_q;

    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0)
        else $error("random source reached zero");

    p_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_q != $past(state_q))
        else $error("random source did not advance");
endmodule

// File: rtl/die_reduce.sv
module die_reduce
    import die_pkg::*;
(
    input  die_kind_e          kind,
    input  logic [RND_W-1:0]   rnd,
    output logic [FACE_W-1:0]  value
);
    logic [RND_W-1:0] rem;

    always_comb begin
        case (kind)
            DIE_D4:  rem = rnd % RND_W'(4);
            DIE_D6:  rem = rnd % RND_W'(6);
            DIE_D8:  rem = rnd % RND_W'(8);
            default: rem = rnd % RND_W'(20);
        endcase
        value = FACE_W'(rem) + FACE_W'(1);
    end

    always_comb begin
        p_span_r5: assert (value >= FACE_W'(1) && value <= sides_of(kind))
            else $error("reduced value outside 1..N");
    end
endmodule

// File: rtl/die_trigger.sv
module die_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("two roll triggers in a row");
endmodule

// File: rtl/poly_die_roller.sv
module poly_die_roller
    import die_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        die_sel,
    input  logic              roll_req,
    output logic [FACE_W-1:0] face
);
    logic [RND_W-1:0]  rnd;
    logic [FACE_W-1:0] reduced;
    logic              rise;
    die_kind_e         kind;
    logic [FACE_W-1:0] face_d, face_q;

    assign kind = die_kind_e'(die_sel);

    die_lfsr #(.W(RND_W), .SEED(SEED), .TAPS(16'hD008)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    die_trigger u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (roll_req),
        .rise  (rise)
    );

    die_reduce u_red (
        .kind  (kind),
        .rnd   (rnd),
        .value (reduced)
    );

    always_comb begin
        face_d = rise ? reduced : face_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) face_q <= '0;
        else        face_q <= face_d;
    end

    assign face = face_q;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rise)) |-> $stable(face_q))
        else $error("face changed without a roll");

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rise)) |->
            (face_q >= 1 && face_q <= sides_of(die_kind_e'($past(die_sel)))))
        else $error("rolled face out of range");
endmodule

// File: tb/tb_poly_die_roller.sv
`timescale 1ns/1ps
module tb_poly_die_roller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] die_sel = 2'b00;
    logic       roll_req = 1'b0;
    logic [7:0] face;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int seen [1:20];

    always #2.5 clk = ~clk;

    poly_die_roller dut (
        .clk(clk), .rst_n(rst_n), .die_sel(die_sel),
        .roll_req(roll_req), .face(face)
    );

    function automatic int sides(input logic [1:0] s);
        case (s)
            2'b00: return 4;
            2'b01: return 6;
            2'b10: return 8;
            default: return 20;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic roll(input logic [1:0] s, input int gap, input int hold);
        int n;
        logic [7:0] v;
        n = sides(s);
        @(negedge clk);
        die_sel = s;
        roll_req = 1'b1;
        @(negedge clk);
        v = face;
        check(v >= 1 && int'(v) <= n, "R5 face in 1..N", v, n);
        if (v >= 1 && v <= 20) seen[v]++;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(face == v, "R4 held request gives no new value", face, v);
        end
        roll_req = 1'b0;
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            check(face == v, "R4 hold between rolls", face, v);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v0;
        int distinct;
        repeat (3) @(negedge clk);
        check(face == 0, "R1 reset value", face, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(face == 0, "R1 zero until first roll", face, 0);

        // R3: face updates at the edge where the request is first high
        die_sel = 2'b11;
        roll_req = 1'b1;
        @(posedge clk);
        #1;
        check(face >= 1 && face <= 20, "R3 value at first edge", face, 20);
        @(negedge clk);
        roll_req = 1'b0;

        // R4: selector change while idle has no effect
        v0 = face;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            die_sel = 2'(s);
            @(negedge clk);
            check(face == v0, "R4 die_sel change ignored", face, v0);
        end

        for (int s = 0; s < 4; s++) begin
            for (int f = 1; f <= 20; f++) seen[f] = 0;
            for (int r = 0; r < 300; r++)
                roll(2'(s), 1 + (r % 5), (r % 7 == 0) ? 3 : 0);
            distinct = 0;
            for (int f = 1; f <= 20; f++) begin
                if (f <= sides(2'(s))) begin
                    check(seen[f] > 0, "R6 face reached within 300 rolls", seen[f], 1);
                    if (seen[f] > 0) distinct++;
                end else begin
                    check(seen[f] == 0, "R2 no face above N for encoding", seen[f], 0);
                end
            end
            check(distinct > 1, "R7 successive rolls vary", distinct, sides(2'(s)));
        end

        // R1: asynchronous clear, checked before any clock edge
        @(negedge clk);
        #0.5;
        rst_n = 1'b0;
        #0.5;
        check(face == 0, "R1 asynchronous clear", face, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule